// File: doc/BRIEF.md
# Paced Parallel Word Output Controller

This block drives a 32-bit parallel output bus from a small first-in first-out store. A producer fills the store over a ready/valid interface. Each stored word is moved onto the output pins in one of two ways. In timer mode a programmable pacer releases one word per tick. In handshake mode the block runs a four-phase exchange with an external receiver: it presents a word, lowers an active-low request, waits for an active-low acknowledge, raises the request again, and waits for the acknowledge to return high before it starts the next word.

The output register can also be loaded directly, and it is always visible on `dout`, so software-side logic reads back the level it wrote. If a timer tick finds the store empty, the pins keep their last value and a sticky underflow flag is set. A one-cycle clear pulse resets that flag. The acknowledge input is asynchronous and passes through a two-flop synchronizer before the handshake logic uses it.

Top module: `pdo_stream_ctrl`

## Requirements
- R1: After reset `dout` is 0, `req_n` is 1 and `uflow_flag` is 0. `in_ready` is 1 only when `cfg_fifo_en` is 1.
- R2: With `cfg_fifo_en` high, the store accepts a word on each cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 0 when the store holds DEPTH (8) words or when `cfg_fifo_en` is 0. Words leave in the order they arrived.
- R3: A cycle with `wr_en` high loads `wr_data` into `dout` at the next edge. A word leaving the store in the same cycle takes priority, and the direct write is then dropped.
- R4: While `cfg_pace_en` is 1, a tick occurs every P cycles, where P = `pace_div`, or P = 2 when `pace_div` is below 2. The first tick comes P cycles after enabling. At a tick with `cfg_fifo_en` high, a non-empty store and no handshake in progress, the oldest word moves to `dout`.
- R5: A tick that meets the conditions of R4 but finds the store empty sets `uflow_flag` at the next edge, and `dout` keeps its value.
- R6: `uflow_flag` stays set until a cycle with `uflow_clr` high clears it. If a set and a clear fall in the same cycle, the set wins.
- R7: In handshake mode (`cfg_pace_en` 0, `cfg_req_en` 1, `cfg_fifo_en` 1), when the handshake is idle and the store is not empty, the oldest word goes to `dout` at the next edge. `req_n` falls one cycle after that.
- R8: With `cfg_ack_en` 1, `req_n` stays low until the synchronized `ack_n` is seen low. It then returns high. A fall of `ack_n` reaches the handshake after two flop stages.
- R9: With `cfg_ack_en` 1, after `req_n` rises no new word is taken until the synchronized `ack_n` is seen high again.
- R10: With `cfg_ack_en` 0, `req_n` goes low for exactly one cycle per word, and `ack_n` is ignored.
- R11: Handshake mode never sets `uflow_flag`. With an empty store it waits.
- R12: When `cfg_pace_en` and `cfg_req_en` are both 1, timer pacing applies and `req_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Producer word |
| in_valid | input | 1 | Producer word valid |
| in_ready | output | 1 | Store can accept a word |
| cfg_pace_en | input | 1 | Timer pacing enable |
| cfg_fifo_en | input | 1 | Store enable |
| cfg_req_en | input | 1 | Request generation enable (handshake mode) |
| cfg_ack_en | input | 1 | Use acknowledge input |
| pace_div | input | 16 | Pacer period in clock cycles |
| wr_en | input | 1 | Direct output write strobe |
| wr_data | input | 32 | Direct output write value |
| dout | output | 32 | Output pins, also the readback value |
| uflow_flag | output | 1 | Sticky underflow status |
| uflow_clr | input | 1 | Clear pulse for the underflow status |
| req_n | output | 1 | Active-low output request |
| ack_n | input | 1 | Active-low acknowledge, asynchronous |

## Verification
If the store's read pointer is wrong, `dout` shows a word out of order or repeated at the very next pacer tick or handshake start. If the handshake state is wrong, `req_n` is low at the wrong time, one to three cycles away from the expected `ack_n` edge, so the error shows up within a single exchange. A pacer counter that is off by one moves every later update by a cycle, so the first word after enabling already lands on a different cycle. A cycle-level reference model compares `dout`, `req_n`, `uflow_flag` and `in_ready` on every cycle, so each of these faults shows up in the first cycle where it becomes visible.

// File: rtl/pdo_pkg.sv
package pdo_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_SETUP = 2'd1,
    HS_REQ   = 2'd2,
    HS_REL   = 2'd3
  } hs_state_e;
endpackage

// File: rtl/pdo_fifo.sv
module pdo_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign head  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/pdo_pacer.sv
module pdo_pacer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  // Smallest legal period is two cycles.
  function automatic logic [DIV_W-1:0] period_of(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(2)) ? DIV_W'(2) : d;
  endfunction

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = period_of(div);
  assign tick = en && (cnt == lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/pdo_ack_sync.sv
module pdo_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  output logic ack_low
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sr[0] <= 1'b1;
        else        sr[0] <= ack_n;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sr[i] <= 1'b1;
        else        sr[i] <= sr[i-1];
      end
    end
  end

  assign ack_low = !sr[STAGES-1];
endmodule

// File: rtl/pdo_hs_fsm.sv
module pdo_hs_fsm
  import pdo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack_en,
  input  logic ack_low,
  output logic idle,
  output logic req_n
);
  hs_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      HS_IDLE:  if (start) st_nx = HS_SETUP;
      HS_SETUP: st_nx = HS_REQ;
      HS_REQ:   if (!ack_en || ack_low)  st_nx = HS_REL;
      HS_REL:   if (!ack_en || !ack_low) st_nx = HS_IDLE;
      default:  st_nx = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= HS_IDLE;
    else        st <= st_nx;
  end

  assign idle  = (st == HS_IDLE);
  assign req_n = (st != HS_REQ);
endmodule

// File: rtl/pdo_stream_ctrl.sv
module pdo_stream_ctrl #(
  parameter int W           = 32,
  parameter int DEPTH       = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             cfg_pace_en,
  input  logic             cfg_fifo_en,
  input  logic             cfg_req_en,
  input  logic             cfg_ack_en,
  input  logic [DIV_W-1:0] pace_div,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     dout,
  output logic             uflow_flag,
  input  logic             uflow_clr,
  output logic             req_n,
  input  logic             ack_n
);
  // Named internal events, also watched by the checker.
  logic         fifo_empty, fifo_full;
  logic [W-1:0] fifo_head;
  logic         push, pop;
  logic         tick, timer_upd, hs_start, uflow_set;
  logic         hs_idle, ack_low;
  logic [W-1:0] dout_q;
  logic         uflow_q;

  assign in_ready  = cfg_fifo_en && !fifo_full;
  assign push      = in_valid && in_ready;
  assign timer_upd = tick && cfg_fifo_en && hs_idle;
  assign hs_start  = hs_idle && !cfg_pace_en && cfg_req_en && cfg_fifo_en && !fifo_empty;
  assign pop       = (timer_upd && !fifo_empty) || hs_start;
  assign uflow_set = timer_upd && fifo_empty;

  pdo_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(in_data),
    .pop(pop), .head(fifo_head), .empty(fifo_empty), .full(fifo_full)
  );

  pdo_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en(cfg_pace_en), .div(pace_div), .tick(tick)
  );

  pdo_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .ack_low(ack_low)
  );

  pdo_hs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(hs_start), .ack_en(cfg_ack_en),
    .ack_low(ack_low), .idle(hs_idle), .req_n(req_n)
  );

  // A stream update outranks a direct write in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)      dout_q <= '0;
    else if (pop)    dout_q <= fifo_head;
    else if (wr_en)  dout_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         uflow_q <= 1'b0;
    else if (uflow_set) uflow_q <= 1'b1;
    else if (uflow_clr) uflow_q <= 1'b0;
  end

  assign dout       = dout_q;
  assign uflow_flag = uflow_q;
endmodule

// File: rtl/pdo_stream_ctrl_chk.sv
module pdo_stream_ctrl_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_pace_en,
  input logic         cfg_ack_en,
  input logic         uflow_clr,
  input logic         wr_en,
  input logic         in_ready,
  input logic         req_n,
  input logic         uflow_flag,
  input logic [W-1:0] dout,
  input logic         fifo_full,
  input logic         fifo_empty,
  input logic         pop,
  input logic         hs_start,
  input logic         uflow_set,
  input logic         ack_low
);
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);  // R2
  AST_READY_OFF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !in_ready);  // R2
  AST_UFLOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_set |=> uflow_flag);  // R5
  AST_UFLOW_HOLDS_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_set && !wr_en |=> $stable(dout));  // R5
  AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_flag && !uflow_clr |=> uflow_flag);  // R6
  AST_REQ_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hs_start |-> ##2 !req_n);  // R7
  AST_REQ_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n && cfg_ack_en && !ack_low |=> !req_n);  // R8
  AST_NO_START_BEFORE_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_n) && cfg_ack_en |=> !hs_start);  // R9
  AST_REQ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n && !cfg_ack_en |=> req_n);  // R10
  AST_NO_UFLOW_HS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pace_en |-> !uflow_set);  // R11
  AST_TIMER_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pace_en && req_n |=> req_n);  // R12
endmodule

bind pdo_stream_ctrl pdo_stream_ctrl_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_pace_en(cfg_pace_en), .cfg_ack_en(cfg_ack_en),
  .uflow_clr(uflow_clr), .wr_en(wr_en), .in_ready(in_ready), .req_n(req_n),
  .uflow_flag(uflow_flag), .dout(dout), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .pop(pop), .hs_start(hs_start),
  .uflow_set(uflow_set), .ack_low(ack_low)
);

// File: tb/pdo_stream_ctrl_tb_top.sv
`timescale 1ns/1ps
module pdo_stream_ctrl_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        cfg_pace_en = 1'b0, cfg_fifo_en = 1'b0, cfg_req_en = 1'b0, cfg_ack_en = 1'b0;
  logic [15:0] pace_div = 16'd5;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] dout;
  logic        uflow_flag;
  logic        uflow_clr = 1'b0;
  logic        req_n;
  logic        ack_n = 1'b1;

  always #5 clk = ~clk;

  pdo_stream_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .cfg_pace_en(cfg_pace_en), .cfg_fifo_en(cfg_fifo_en),
    .cfg_req_en(cfg_req_en), .cfg_ack_en(cfg_ack_en), .pace_div(pace_div),
    .wr_en(wr_en), .wr_data(wr_data), .dout(dout), .uflow_flag(uflow_flag),
    .uflow_clr(uflow_clr), .req_n(req_n), .ack_n(ack_n)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  bit    run_cmp = 1'b0;
  string phase = "R3";
  int    req_low_cnt = 0;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] q[$];
  logic [31:0] m_dout;
  bit          m_uf;
  int          m_phase;   // 0 idle, 1 word shown, 2 request low, 3 waiting for ack high
  int          m_cnt;
  bit          m_s1, m_s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_dout = '0; m_uf = 0; m_phase = 0; m_cnt = 0; m_s1 = 1; m_s2 = 1;
    end else begin
      int  per;
      bit  rdy, tk, upd, hst, take, ufs, ackl;
      per  = (pace_div < 2) ? 2 : int'(pace_div);
      rdy  = cfg_fifo_en && (q.size() < DEPTH);
      tk   = cfg_pace_en && (m_cnt == per - 1);
      upd  = tk && cfg_fifo_en && (m_phase == 0);
      hst  = (m_phase == 0) && !cfg_pace_en && cfg_req_en && cfg_fifo_en && (q.size() > 0);
      take = (upd && q.size() > 0) || hst;
      ufs  = upd && (q.size() == 0);
      ackl = !m_s2;
      if (take) m_dout = q.pop_front();
      else if (wr_en) m_dout = wr_data;
      if (in_valid && rdy) q.push_back(in_data);
      if (ufs) m_uf = 1; else if (uflow_clr) m_uf = 0;
      if (!cfg_pace_en) m_cnt = 0; else if (tk) m_cnt = 0; else m_cnt++;
      case (m_phase)
        0: if (hst) m_phase = 1;
        1: m_phase = 2;
        2: if (!cfg_ack_en || ackl) m_phase = 3;
        default: if (!cfg_ack_en || !ackl) m_phase = 0;
      endcase
      m_s2 = m_s1;
      m_s1 = ack_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(phase, "dout", dout, m_dout);
      chk(phase, "req_n", {31'b0, req_n}, {31'b0, (m_phase == 2) ? 1'b0 : 1'b1});
      chk(phase, "uflow_flag", {31'b0, uflow_flag}, {31'b0, m_uf});
      chk("R2", "in_ready", {31'b0, in_ready},
          {31'b0, cfg_fifo_en && (q.size() < DEPTH)});
      if (!req_n) req_low_cnt++;
    end
  end

  // External receiver: answers request and release after resp_dly cycles
  bit resp_on = 1'b0;
  int resp_dly = 3;
  int rc = 0;
  always @(posedge clk) begin
    #2;
    if (!resp_on) rc = 0;
    else if (!req_n && ack_n) begin
      rc++;
      if (rc > resp_dly) begin ack_n = 1'b0; rc = 0; end
    end else if (req_n && !ack_n) begin
      rc++;
      if (rc > resp_dly) begin ack_n = 1'b1; rc = 0; end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic push_word(input logic [31:0] d);
    bit r;
    in_valid = 1'b1;
    in_data  = d;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      r = in_ready;
      @(posedge clk);
      #2;
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset dout", dout, 32'h0);
    chk("R1", "reset req_n", {31'b0, req_n}, 32'h1);
    chk("R1", "reset uflow", {31'b0, uflow_flag}, 32'h0);
    chk("R1", "reset in_ready", {31'b0, in_ready}, 32'h0);
    step(1);
    run_cmp = 1'b1;

    phase = "R3";
    wr_en = 1'b1; wr_data = 32'hA5A5_0001; step(1);
    wr_en = 1'b0; step(2);
    wr_en = 1'b1; wr_data = 32'h5A5A_FFFE; step(1);
    wr_en = 1'b0; step(1);

    phase = "R2";
    cfg_fifo_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) push_word(32'h1000_0000 + i);
    in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
    step(4);
    chk("R2", "in_ready when full", {31'b0, in_ready}, 32'h0);
    in_valid = 1'b0;
    cfg_fifo_en = 1'b0; step(2);
    cfg_fifo_en = 1'b1; step(1);

    phase = "R4";
    pace_div = 16'd5;
    cfg_pace_en = 1'b1;
    step(17);
    phase = "R3";
    wr_en = 1'b1; wr_data = 32'h0BAD_F00D; step(12);
    wr_en = 1'b0;
    phase = "R4";
    step(15);
    phase = "R5";
    step(15);
    chk("R5", "underflow raised", {31'b0, uflow_flag}, 32'h1);

    phase = "R6";
    uflow_clr = 1'b1; step(12);
    uflow_clr = 1'b0;
    cfg_pace_en = 1'b0; step(3);
    uflow_clr = 1'b1; step(1);
    uflow_clr = 1'b0; step(1);
    chk("R6", "flag cleared", {31'b0, uflow_flag}, 32'h0);

    phase = "R4";
    pace_div = 16'd0;
    for (int i = 0; i < 4; i++) push_word(32'h2000_0000 + i);
    cfg_pace_en = 1'b1; step(12);
    cfg_pace_en = 1'b0; uflow_clr = 1'b1; step(1);
    uflow_clr = 1'b0; step(2);

    phase = "R7";
    resp_on = 1'b1; resp_dly = 3;
    cfg_req_en = 1'b1; cfg_ack_en = 1'b1;
    push_word(32'h3000_0000);
    step(20);
    phase = "R8";
    for (int i = 1; i < 4; i++) push_word(32'h3000_0000 + i);
    step(60);
    phase = "R9";
    resp_dly = 0;
    for (int i = 4; i < 8; i++) push_word(32'h3000_0000 + i);
    step(60);

    phase = "R11";
    step(30);
    chk("R11", "no underflow in handshake", {31'b0, uflow_flag}, 32'h0);

    phase = "R10";
    resp_on = 1'b0; ack_n = 1'b1;
    cfg_ack_en = 1'b0;
    for (int i = 0; i < 3; i++) push_word(32'h4000_0000 + i);
    step(30);

    phase = "R12";
    cfg_ack_en = 1'b1;
    cfg_pace_en = 1'b1; pace_div = 16'd3;
    step(1);
    req_low_cnt = 0;
    for (int i = 0; i < 4; i++) push_word(32'h5000_0000 + i);
    step(30);
    chk("R12", "request cycles under timer", req_low_cnt, 32'h0);

    run_cmp = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule